// File: doc/BRIEF.md
# Fixed-Priority Interrupt Controller with In-Service Tracking

This block collects sixteen interrupt lines and ranks them in a fixed order. A rising edge on a line latches into that channel's pending bit. A single request output goes to the processor when the best pending channel outranks every channel already being serviced. The processor answers with a one-cycle acknowledge. At that edge the block reports the chosen channel number, clears that channel's pending bit and marks it in service.

Software sees the sixteen channels as two 8-bit banks. It reaches the pending and in-service flags of each bank through a small synchronous register port. Writes can only clear flags: a 0 bit clears and a 1 bit leaves the flag alone. An in-service flag that is set holds back every channel below it and the channel itself. Higher channels can still interrupt. A repeat event on a channel already in service waits in its pending flag until software clears the in-service flag, normally at the end of its handler.

Top module: `irq_prio_ctrl`

## Requirements
- R1: While rst_ni is low, all pending and in-service flags are 0, irq_o is 0 and every register reads 0.
- R2: A 0-to-1 change on irq_i[n], seen between two rising clock edges, sets pending flag n at the next edge. A line that stays high sets the flag only once, so a software clear made while the line stays high is not undone.
- R3: Register addresses, as read on reg_rdata_o in the same cycle as the address is presented:
  - 0 is pending for channels 15..8, where bit k is channel 8+k.
  - 1 is pending for channels 7..0, where bit k is channel k.
  - 2 is in-service for channels 15..8.
  - 3 is in-service for channels 7..0.
  Reads have no side effects.
- R4: A write to a pending register clears each flag whose write-data bit is 0 and leaves each flag whose bit is 1 unchanged.
- R5: A write to an in-service register clears each flag whose write-data bit is 0. A 1 bit leaves the flag unchanged, so software can never set an in-service flag.
- R6: Channel 15 ranks highest and channel 0 lowest. While irq_o is 1, ack_id_o gives the highest pending channel.
- R7: irq_o is 1 exactly when some channel is pending and the highest pending channel ranks strictly above the highest in-service channel, or no channel is in service. An in-service channel therefore blocks lower channels and its own repeat events, but not higher ones.
- R8: An ack_i pulse while irq_o is 1 clears the pending flag of ack_id_o and sets its in-service flag at that clock edge. ack_i while irq_o is 0 changes nothing.
- R9: When a new edge and a clear reach the same pending flag in the same cycle, the flag ends up set. The clear may come from software or from an acknowledge.
- R10: When an acknowledge sets an in-service flag that a software write clears in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 16 | Interrupt lines, synchronous to clk_i, rising-edge sensitive |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Write data, 0 bits clear |
| reg_rdata_o | output | 8 | Read data of the selected register |
| irq_o | output | 1 | Service request to the processor |
| ack_i | input | 1 | Acknowledge pulse |
| ack_id_o | output | 4 | Channel number of the current winner |

## Verification
The properties assume the following about the inputs:
- irq_i, ack_i and the register port are already synchronous to clk_i.
- irq_i is held low during reset, so no edge is seen in the first cycle after reset.
- ack_i is only meaningful as a single-cycle pulse.

The bench changes every input at the falling clock edge and lowers pulsed lines before the next edge is needed. It keeps irq_i at 0 across both resets. It deliberately makes edges, clears and acknowledges collide in one cycle, to reach the R9 and R10 tie-breaks.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int unsigned CH_DEF   = 16;
  localparam int unsigned BANK_DEF = 8;

  // register address of a bank: pending block first, in-service block after
  function automatic int unsigned bank_addr(input int unsigned n_bank, input int unsigned bank,
                                            input bit in_service);
    return (in_service ? n_bank : 0) + (n_bank - 1 - bank);
  endfunction
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N = 16,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     in_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  // highest set index wins
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (in_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_bank_regs.sv
module irq_bank_regs #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] edge_i,
  input  logic         pend_wr_i,
  input  logic         isr_wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] ack_hit_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] isr_o
);
  logic [W-1:0] pend_q, isr_q, pend_clr, isr_clr, pend_d, isr_d;

  assign pend_clr = pend_wr_i ? ~wdata_i : '0;
  assign isr_clr  = isr_wr_i  ? ~wdata_i : '0;

  // new edge beats any clear; ack set beats software clear
  assign pend_d = (pend_q & ~pend_clr & ~ack_hit_i) | edge_i;
  assign isr_d  = (isr_q & ~isr_clr) | ack_hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      isr_q  <= '0;
    end else begin
      pend_q <= pend_d;
      isr_q  <= isr_d;
    end
  end

  assign pend_o = pend_q;
  assign isr_o  = isr_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int unsigned N_CH   = irq_prio_pkg::CH_DEF,
  parameter int unsigned BANK_W = irq_prio_pkg::BANK_DEF,
  localparam int unsigned ID_W   = $clog2(N_CH),
  localparam int unsigned N_BANK = N_CH / BANK_W,
  localparam int unsigned ADDR_W = $clog2(2 * N_BANK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_CH-1:0]   irq_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BANK_W-1:0] reg_wdata_i,
  output logic [BANK_W-1:0] reg_rdata_o,
  output logic              irq_o,
  input  logic              ack_i,
  output logic [ID_W-1:0]   ack_id_o
);
  import irq_prio_pkg::*;

  logic [N_CH-1:0] irq_q, irq_edge, pend_all, isr_all, ack_hit;
  logic            p_valid, s_valid, ack_take;
  logic [ID_W-1:0] p_idx, s_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_i;
  end

  assign irq_edge = irq_i & ~irq_q;

  irq_prio_enc #(.N(N_CH)) u_pend_enc (.in_i(pend_all), .valid_o(p_valid), .idx_o(p_idx));
  irq_prio_enc #(.N(N_CH)) u_isr_enc  (.in_i(isr_all),  .valid_o(s_valid), .idx_o(s_idx));

  assign irq_o    = p_valid && (!s_valid || (p_idx > s_idx));
  assign ack_id_o = p_idx;
  assign ack_take = ack_i && irq_o;
  assign ack_hit  = ack_take ? (N_CH'(1) << p_idx) : '0;

  for (genvar b = 0; b < int'(N_BANK); b++) begin : g_bank
    localparam int unsigned PEND_A = bank_addr(N_BANK, b, 1'b0);
    localparam int unsigned ISR_A  = bank_addr(N_BANK, b, 1'b1);
    logic pend_wr, isr_wr;

    assign pend_wr = reg_we_i && (reg_addr_i == ADDR_W'(PEND_A));
    assign isr_wr  = reg_we_i && (reg_addr_i == ADDR_W'(ISR_A));

    irq_bank_regs #(.W(BANK_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .edge_i   (irq_edge[b*BANK_W +: BANK_W]),
      .pend_wr_i(pend_wr),
      .isr_wr_i (isr_wr),
      .wdata_i  (reg_wdata_i),
      .ack_hit_i(ack_hit[b*BANK_W +: BANK_W]),
      .pend_o   (pend_all[b*BANK_W +: BANK_W]),
      .isr_o    (isr_all[b*BANK_W +: BANK_W])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int b = 0; b < int'(N_BANK); b++) begin
      if (reg_addr_i == ADDR_W'(bank_addr(N_BANK, b, 1'b0)))
        reg_rdata_o = pend_all[b*BANK_W +: BANK_W];
      if (reg_addr_i == ADDR_W'(bank_addr(N_BANK, b, 1'b1)))
        reg_rdata_o = isr_all[b*BANK_W +: BANK_W];
    end
  end
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk #(
  parameter int unsigned N_CH   = 16,
  parameter int unsigned BANK_W = 8,
  localparam int unsigned ID_W   = $clog2(N_CH),
  localparam int unsigned N_BANK = N_CH / BANK_W,
  localparam int unsigned ADDR_W = $clog2(2 * N_BANK)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [BANK_W-1:0] reg_wdata_i,
  input logic              irq_o,
  input logic              ack_i,
  input logic [ID_W-1:0]   ack_id_o,
  input logic [N_CH-1:0]   irq_edge,
  input logic [N_CH-1:0]   pend_all,
  input logic [N_CH-1:0]   isr_all
);
  // R5
  isr_sw_no_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((isr_all & ~$past(isr_all)) != '0) |-> $past(ack_i && irq_o));

  // R5
  isr_ones_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i >= ADDR_W'(N_BANK) && (&reg_wdata_i) && !(ack_i && irq_o))
    |=> $stable(isr_all));

  // R4
  pend_ones_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i < ADDR_W'(N_BANK) && (&reg_wdata_i) && !(ack_i && irq_o))
    |=> (($past(pend_all) & ~pend_all) == '0));

  // R2
  pend_set_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_all & ~$past(pend_all) & ~$past(irq_edge)) == '0);

  // R9
  edge_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(irq_edge) & ~pend_all) == '0);

  // R8
  ack_marks_isr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> isr_all[$past(ack_id_o)]);

  // R7
  req_not_in_service_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend_all[ack_id_o] && !isr_all[ack_id_o]));
endmodule

bind irq_prio_ctrl irq_prio_chk #(.N_CH(N_CH), .BANK_W(BANK_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .irq_o      (irq_o),
  .ack_i      (ack_i),
  .ack_id_o   (ack_id_o),
  .irq_edge   (irq_edge),
  .pend_all   (pend_all),
  .isr_all    (isr_all)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq_out;
  logic        ack = 1'b0;
  logic [3:0]  ack_id;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  irq_prio_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq_out), .ack_i(ack), .ack_id_o(ack_id)
  );

  typedef struct packed {
    logic [15:0] pulse;
    logic        do_ack;
    logic        exp_irq;
    logic [3:0]  exp_id;
  } vec_t;

  localparam vec_t VECS [0:4] = '{
    '{16'h0008, 1'b1, 1'b1, 4'd3},  // ch3 alone, taken
    '{16'h0002, 1'b0, 1'b0, 4'd0},  // ch1 blocked by ch3 in service
    '{16'h0008, 1'b0, 1'b0, 4'd0},  // repeat on ch3 waits
    '{16'h0200, 1'b1, 1'b1, 4'd9},  // ch9 preempts
    '{16'h0000, 1'b0, 1'b0, 4'd0}   // nothing new
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_reg(input string req, input logic [1:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(req, int'(rdata), int'(exp));
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    we = 1'b1; addr = a; wdata = d;
    step();
    we = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] p);
    irq = p;
    step();
    irq = '0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state
    @(negedge clk); @(negedge clk);
    chk("R1 irq_o", int'(irq_out), 0);
    for (int a = 0; a < 4; a++) chk_reg("R1 reg", 2'(a), 8'h00);
    rst_n = 1'b1;
    step();

    // table walk: R6 R7 R8
    for (int v = 0; v < 5; v++) begin
      pulse(VECS[v].pulse);
      chk("R7 irq_o", int'(irq_out), int'(VECS[v].exp_irq));
      if (VECS[v].exp_irq) chk("R6 ack_id", int'(ack_id), int'(VECS[v].exp_id));
      if (VECS[v].do_ack) begin
        ack = 1'b1; step(); ack = 1'b0;
      end
    end
    // pend {1,3}, isr {3,9}
    chk_reg("R3 pend hi", 2'd0, 8'h00);
    chk_reg("R3 pend lo", 2'd1, 8'h0A);
    chk_reg("R3 isr hi",  2'd2, 8'h02);
    chk_reg("R3 isr lo",  2'd3, 8'h08);

    wr(2'd2, 8'hFD);  // clear ch9 in service
    chk_reg("R5 clear one", 2'd2, 8'h00);
    chk("R7 repeat waits", int'(irq_out), 0);
    wr(2'd3, 8'hF7);  // clear ch3 in service
    chk("R7 repeat released", int'(irq_out), 1);
    chk("R6 id", int'(ack_id), 3);
    wr(2'd3, 8'hFF);
    chk_reg("R5 no set", 2'd3, 8'h00);

    ack = 1'b1; step(); ack = 1'b0;
    chk_reg("R8 pend cleared", 2'd1, 8'h02);
    chk_reg("R8 isr set", 2'd3, 8'h08);
    chk("R7 lower blocked", int'(irq_out), 0);

    wr(2'd1, 8'hFF);
    chk_reg("R4 ones keep", 2'd1, 8'h02);
    wr(2'd1, 8'hFD);
    chk_reg("R4 zero clears", 2'd1, 8'h00);

    // R2 held level latches once
    irq = 16'h0010;
    step();
    chk_reg("R2 edge sets", 2'd1, 8'h10);
    step();
    wr(2'd1, 8'hEF);
    chk_reg("R2 held no relatch", 2'd1, 8'h00);
    step();
    chk_reg("R2 held no relatch 2", 2'd1, 8'h00);
    irq = '0;
    step();

    // R9 edge vs software clear
    pulse(16'h0004);
    chk_reg("R2 ch2", 2'd1, 8'h04);
    irq = 16'h0020; we = 1'b1; addr = 2'd1; wdata = 8'h00;
    step();
    we = 1'b0; irq = '0;
    chk_reg("R9 edge beats sw clear", 2'd1, 8'h20);
    chk("R6 id ch5", int'(ack_id), 5);
    step();

    // R9 edge vs ack clear
    ack = 1'b1; irq = 16'h0020;
    step();
    ack = 1'b0; irq = '0;
    chk_reg("R9 edge beats ack clear", 2'd1, 8'h20);
    chk_reg("R8 isr ch5", 2'd3, 8'h28);
    chk("R7 repeat ch5 waits", int'(irq_out), 0);

    // R10 ack set vs software clear
    wr(2'd3, 8'h00);
    chk("R7 released ch5", int'(irq_out), 1);
    ack = 1'b1; we = 1'b1; addr = 2'd3; wdata = 8'hDF;
    step();
    ack = 1'b0; we = 1'b0;
    chk_reg("R10 ack set wins", 2'd3, 8'h20);
    chk_reg("R8 pend taken", 2'd1, 8'h00);

    // R8 ack without request ignored
    chk("R8 idle", int'(irq_out), 0);
    ack = 1'b1; step(); ack = 1'b0;
    chk_reg("R8 ignored isr", 2'd3, 8'h20);
    chk_reg("R8 ignored pend", 2'd1, 8'h00);

    // R6 top channel and bank mapping
    wr(2'd3, 8'h00);
    pulse(16'h8101);
    chk("R6 irq", int'(irq_out), 1);
    chk("R6 top wins", int'(ack_id), 15);
    chk_reg("R3 pend hi map", 2'd0, 8'h81);
    chk_reg("R3 pend lo map", 2'd1, 8'h01);
    ack = 1'b1; step(); ack = 1'b0;
    chk_reg("R8 isr ch15", 2'd2, 8'h80);
    chk("R7 all lower blocked", int'(irq_out), 0);

    // R1 reset in mid run
    rst_n = 1'b0;
    #1;
    chk("R1 irq_o again", int'(irq_out), 0);
    for (int a = 0; a < 4; a++) chk_reg("R1 reg again", 2'(a), 8'h00);

    if (!done) begin
      done = 1'b1;
      summary();
      $finish;
    end
  end
endmodule